// File: doc/BRIEF.md
# Break-Immediate Execution Unit

This unit carries out a single break-immediate instruction for a 32-bit soft processor core. On an issue pulse it decodes the instruction word and forms the branch target. The target is either the sign-extended 16-bit immediate or a full 32-bit value built from a pending upper-immediate prefix. The unit also decides whether the attempt is allowed in the current privilege mode and prepares the new machine status word. A short sequencer then holds the result for the instruction's fixed latency and commits everything in one cycle.

When it commits, the core receives one of two outcomes. A normal branch gives the link value and register write for rD, the new PC, the updated status word and a reservation-clear pulse. A privileged-instruction fault gives an exception request with its cause code, and no architectural write. A software break to one of two vector offsets is exempt from the privilege check and drops the core out of user and virtual mode. With debug support on, a break to immediate 0x0018 ignores any prefix.

Top module: `brk_imm_unit`

## Requirements
- R1: An issue pulse starts the unit only when instr[31:26] is 101110 and instr[20:16] is 01100. Any other word leaves busy and done low.
- R2: With no prefix pending, the target is instr[15:0] sign-extended to 32 bits. With a prefix pending, the target is {pfx_hi, instr[15:0]}.
- R3: A normal commit asserts rd_we with rd_addr = instr[25:21] and rd_data = the issuing PC. It also asserts pc_we with pc_next = target, msr_we with status bit 3 (branch-in-progress) set, and resv_clr. exc_raise stays low.
- R4: With the MMU enabled and status bit 11 (user mode) set, a target other than base+0x8 or base+0x18 raises exc_raise with exc_code = 5'b00111.
- R5: On a raised exception, rd_we, pc_we, msr_we and resv_clr stay low.
- R6: With the MMU enabled and the target equal to base+0x8 or base+0x18, the committed status word has bit 11 (user mode) and bit 13 (virtual mode) cleared.
- R7: With debug enabled, an immediate of 0x0018 ignores a pending prefix, whatever the base value.
- R8: busy is high for the two cycles after the issue edge and done is high in the third. No output write or exception appears outside done.
- R9: pfx_clr is high on every done cycle, whether the instruction commits or faults.
- R10: With the MMU disabled, no exception is raised and status bits 11 and 13 pass through unchanged.
- R11: Every status bit other than 3, 11 and 13 passes through unchanged.
- R12: An issue pulse while busy is high is ignored. An issue pulse in the done cycle starts the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Instruction presented for execution |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| pfx_valid | input | 1 | An upper-immediate prefix is pending |
| pfx_hi | input | 16 | Upper half supplied by the prefix |
| msr_in | input | 32 | Current machine status word |
| cfg_mmu_en | input | 1 | Memory management present (privilege enforced) |
| cfg_dbg_en | input | 1 | Debug support present |
| cfg_base_vec | input | 32 | Base address of the vector table |
| busy | output | 1 | Instruction in flight, not yet complete |
| done | output | 1 | Completion cycle |
| rd_we | output | 1 | Register file write enable |
| rd_addr | output | 5 | Register file write index |
| rd_data | output | 32 | Link value |
| pc_we | output | 1 | PC load enable |
| pc_next | output | 32 | Branch target |
| msr_we | output | 1 | Status word write enable |
| msr_out | output | 32 | New status word |
| resv_clr | output | 1 | Clear the load/store reservation |
| exc_raise | output | 1 | Privileged-instruction exception request |
| exc_code | output | 5 | Exception cause code |
| pfx_clr | output | 1 | Consume the pending prefix |

## Verification
The completion of one instruction and the acceptance of the next can fall in the same cycle. The bench provokes this by raising issue with a second word exactly on the done cycle of the first. It judges that the first instruction's committed values are intact in that cycle. It then checks that busy goes high in the following cycle and that the second instruction's own target and link appear three cycles later. It also presents an issue while busy is high with a different word, and confirms that the first result survives unchanged and that no extra done follows.

// File: rtl/brk_pkg.sv
// Shared constants for the break-immediate execution unit.
// Assumes a 32-bit datapath and the fixed instruction encoding.
package brk_pkg;
    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int REG_W  = 5;
    localparam int CODE_W = 5;

    localparam logic [5:0]       OPC_BRK   = 6'b101110;
    localparam logic [REG_W-1:0] RA_BRKI   = 5'b01100;
    localparam logic [IMM_W-1:0] DBG_IMM   = 16'h0018;
    localparam logic [CODE_W-1:0] EC_PRIV  = 5'b00111;

    // status word bit positions
    localparam int ST_BIP = 3;
    localparam int ST_UM  = 11;
    localparam int ST_VM  = 13;

    // exempt software-break offsets from the vector base
    localparam int N_SWBRK = 2;
    localparam logic [N_SWBRK-1:0][XLEN-1:0] SWBRK_OFS = {32'h0000_0018, 32'h0000_0008};

    localparam logic [XLEN-1:0] ST_TOUCHED =
        (XLEN'(1) << ST_BIP) | (XLEN'(1) << ST_UM) | (XLEN'(1) << ST_VM);
endpackage

// File: rtl/brk_decode.sv
// Recognizes the break-immediate word and forms the branch target.
// Assumes the prefix inputs are meaningful only when pfx_valid is high.
module brk_decode
    import brk_pkg::*;
(
    input  logic [XLEN-1:0]  instr,
    input  logic             pfx_valid,
    input  logic [IMM_W-1:0] pfx_hi,
    input  logic             dbg_en,
    output logic             hit,
    output logic [REG_W-1:0] rd_idx,
    output logic [XLEN-1:0]  target
);
    logic [IMM_W-1:0] imm;
    logic             use_pfx;

    // field extraction and opcode match
    always_comb begin
        imm    = instr[IMM_W-1:0];
        rd_idx = instr[25:21];
        hit    = (instr[31:26] == OPC_BRK) && (instr[20:16] == RA_BRKI);
    end

    // target: prefix concatenation unless the debug break exemption applies
    always_comb begin
        use_pfx = pfx_valid && !(dbg_en && (imm == DBG_IMM));
        if (use_pfx)
            target = {pfx_hi, imm};
        else
            target = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    end
endmodule

// File: rtl/brk_priv.sv
// Privilege check and status-word update for a break to a given target.
// Assumes target is already resolved; purely combinational.
module brk_priv
    import brk_pkg::*;
(
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] msr_in,
    input  logic [XLEN-1:0] base_vec,
    input  logic            mmu_en,
    output logic            fault,
    output logic [XLEN-1:0] msr_new
);
    logic sw_brk;

    // is the target one of the exempt software-break vectors
    always_comb begin
        sw_brk = 1'b0;
        for (int i = 0; i < N_SWBRK; i++) begin
            if (target == base_vec + SWBRK_OFS[i])
                sw_brk = 1'b1;
        end
    end

    // fault decision and new status word
    always_comb begin
        fault   = mmu_en && msr_in[ST_UM] && !sw_brk;
        msr_new = msr_in;
        msr_new[ST_BIP] = 1'b1;
        if (mmu_en && sw_brk) begin
            msr_new[ST_UM] = 1'b0;
            msr_new[ST_VM] = 1'b0;
        end
    end
endmodule

// File: rtl/brk_seq.sv
// Latency sequencer: busy for LATENCY-1 cycles after acceptance, done on the last.
// Assumes LATENCY >= 2; a new issue is taken when idle or on the done cycle.
module brk_seq #(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] LAST = CW'(LATENCY);

    logic [CW-1:0] cnt;

    // acceptance and status decode
    always_comb begin
        done  = (cnt == LAST);
        busy  = (cnt != '0) && !done;
        start = req && !busy;
    end

    // cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(1);
        else if (done)
            cnt <= '0;
        else if (busy)
            cnt <= cnt + CW'(1);
    end

    p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |-> !start);
endmodule

// File: rtl/brk_imm_unit.sv
// Break-immediate execution unit: decodes, checks privilege, and commits
// the link, PC, status and reservation updates after a fixed latency.
// Assumes all inputs are valid in the issue cycle; they are captured then.
module brk_imm_unit
    import brk_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   pc,
    input  logic              pfx_valid,
    input  logic [IMM_W-1:0]  pfx_hi,
    input  logic [XLEN-1:0]   msr_in,
    input  logic              cfg_mmu_en,
    input  logic              cfg_dbg_en,
    input  logic [XLEN-1:0]   cfg_base_vec,
    output logic              busy,
    output logic              done,
    output logic              rd_we,
    output logic [REG_W-1:0]  rd_addr,
    output logic [XLEN-1:0]   rd_data,
    output logic              pc_we,
    output logic [XLEN-1:0]   pc_next,
    output logic              msr_we,
    output logic [XLEN-1:0]   msr_out,
    output logic              resv_clr,
    output logic              exc_raise,
    output logic [CODE_W-1:0] exc_code,
    output logic              pfx_clr
);
    logic             hit, start, fault;
    logic [REG_W-1:0] rd_idx;
    logic [XLEN-1:0]  target, msr_new;

    logic             r_fault, r_mmu;
    logic [REG_W-1:0] r_rd;
    logic [XLEN-1:0]  r_link, r_target, r_msr_new, r_msr_old;

    brk_decode u_dec (
        .instr     (instr),
        .pfx_valid (pfx_valid),
        .pfx_hi    (pfx_hi),
        .dbg_en    (cfg_dbg_en),
        .hit       (hit),
        .rd_idx    (rd_idx),
        .target    (target)
    );

    brk_priv u_priv (
        .target   (target),
        .msr_in   (msr_in),
        .base_vec (cfg_base_vec),
        .mmu_en   (cfg_mmu_en),
        .fault    (fault),
        .msr_new  (msr_new)
    );

    brk_seq #(.LATENCY(LATENCY)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (issue && hit),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    // capture the resolved result at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_fault   <= 1'b0;
            r_mmu     <= 1'b0;
            r_rd      <= '0;
            r_link    <= '0;
            r_target  <= '0;
            r_msr_new <= '0;
            r_msr_old <= '0;
        end else if (start) begin
            r_fault   <= fault;
            r_mmu     <= cfg_mmu_en;
            r_rd      <= rd_idx;
            r_link    <= pc;
            r_target  <= target;
            r_msr_new <= msr_new;
            r_msr_old <= msr_in;
        end
    end

    // commit strobes, gated to the done cycle
    always_comb begin
        rd_we     = done && !r_fault;
        pc_we     = done && !r_fault;
        msr_we    = done && !r_fault;
        resv_clr  = done && !r_fault;
        exc_raise = done && r_fault;
        exc_code  = (done && r_fault) ? EC_PRIV : '0;
        pfx_clr   = done;
        rd_addr   = r_rd;
        rd_data   = r_link;
        pc_next   = r_target;
        msr_out   = r_msr_new;
    end

    p_exc_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> !(rd_we || pc_we || msr_we || resv_clr));
    p_commit_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || pc_we || msr_we || exc_raise) |-> done);
    p_pfx_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pfx_clr);
    p_bip_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msr_we |-> msr_out[ST_BIP]);
    p_keep_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        msr_we |-> ((msr_out & ~ST_TOUCHED) == (r_msr_old & ~ST_TOUCHED)));
    p_mmu_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r_mmu) |-> (!exc_raise && msr_out[ST_UM] == r_msr_old[ST_UM]
                              && msr_out[ST_VM] == r_msr_old[ST_VM]));
    p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> (exc_code == 5'b00111));
endmodule

// File: tb/sim_brk_imm_unit.sv
`timescale 1ns/1ps
module sim_brk_imm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = '0, pc = '0, msr_in = '0, cfg_base_vec = '0;
    logic        pfx_valid = 1'b0, cfg_mmu_en = 1'b0, cfg_dbg_en = 1'b0;
    logic [15:0] pfx_hi = '0;
    logic        busy, done, rd_we, pc_we, msr_we, resv_clr, exc_raise, pfx_clr;
    logic [4:0]  rd_addr, exc_code;
    logic [31:0] rd_data, pc_next, msr_out;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    brk_imm_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .pc(pc),
        .pfx_valid(pfx_valid), .pfx_hi(pfx_hi), .msr_in(msr_in),
        .cfg_mmu_en(cfg_mmu_en), .cfg_dbg_en(cfg_dbg_en), .cfg_base_vec(cfg_base_vec),
        .busy(busy), .done(done), .rd_we(rd_we), .rd_addr(rd_addr), .rd_data(rd_data),
        .pc_we(pc_we), .pc_next(pc_next), .msr_we(msr_we), .msr_out(msr_out),
        .resv_clr(resv_clr), .exc_raise(exc_raise), .exc_code(exc_code), .pfx_clr(pfx_clr)
    );

    typedef struct packed {
        logic [15:0] imm;
        logic        pv;
        logic [15:0] ph;
        logic [31:0] msr;
        logic        mmu;
        logic        dbg;
        logic [31:0] base;
        logic        exc;
        logic [31:0] epc;
        logic [31:0] emsr;
    } vec_t;

    localparam int NV = 17;
    // UM = 0x800, VM = 0x2000, BIP = 0x8
    localparam vec_t VT [NV] = '{
        '{16'h0100, 1'b0, 16'h0000, 32'h0000_0000, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0000_0100, 32'h0000_0008}, // R2 R3
        '{16'h8000, 1'b0, 16'h0000, 32'h0000_0000, 1'b0, 1'b0, 32'h0, 1'b0, 32'hFFFF_8000, 32'h0000_0008}, // R2 sign
        '{16'h1234, 1'b1, 16'hABCD, 32'h0000_0000, 1'b0, 1'b0, 32'h0, 1'b0, 32'hABCD_1234, 32'h0000_0008}, // R2 prefix
        '{16'h0100, 1'b0, 16'h0000, 32'h0000_0800, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0,         32'h0},         // R4
        '{16'h0008, 1'b0, 16'h0000, 32'h0000_2800, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0000_0008, 32'h0000_0008}, // R6
        '{16'h1018, 1'b0, 16'h0000, 32'h0000_2800, 1'b1, 1'b0, 32'h1000, 1'b0, 32'h0000_1018, 32'h0000_0008}, // R6 base
        '{16'h0008, 1'b0, 16'h0000, 32'h0000_2800, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0000_0008, 32'h0000_2808}, // R10
        '{16'h0018, 1'b0, 16'h0000, 32'h0000_2000, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0000_0018, 32'h0000_0008}, // R6 VM
        '{16'h0100, 1'b0, 16'h0000, 32'h0000_0000, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0000_0100, 32'h0000_0008}, // R4 UM=0
        '{16'h0018, 1'b1, 16'h5555, 32'h0000_0000, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0000_0018, 32'h0000_0008}, // R7
        '{16'h0018, 1'b1, 16'h5555, 32'h0000_0000, 1'b0, 1'b0, 32'h0, 1'b0, 32'h5555_0018, 32'h0000_0008}, // R7 off
        '{16'h0008, 1'b1, 16'h0001, 32'h0000_0000, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0001_0008, 32'h0000_0008}, // R7 only 0x18
        '{16'h0018, 1'b1, 16'h7777, 32'h0000_0800, 1'b1, 1'b1, 32'h0, 1'b0, 32'h0000_0018, 32'h0000_0008}, // R7+R6
        '{16'h1008, 1'b1, 16'h0000, 32'h0000_0800, 1'b1, 1'b0, 32'h1000, 1'b0, 32'h0000_1008, 32'h0000_0008}, // R6 via prefix
        '{16'h0200, 1'b0, 16'h0000, 32'hF0F0_0001, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0000_0200, 32'hF0F0_0009}, // R11
        '{16'h0010, 1'b0, 16'h0000, 32'h0000_0800, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0,         32'h0},         // R4 not exempt
        '{16'h0008, 1'b1, 16'h0001, 32'h0000_0800, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0,         32'h0}          // R4 prefix moves target
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rd, input logic [15:0] imm);
        return {6'b101110, rd, 5'b01100, imm};
    endfunction

    task automatic finish_sim();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // check the done cycle of a normal commit
    task automatic chk_commit(input string tag, input logic [4:0] rd, input logic [31:0] link,
                              input logic [31:0] tgt);
        chk({tag, " R8 done"}, 32'(done), 1);
        chk({tag, " R3 rd_we"}, 32'(rd_we), 1);
        chk({tag, " R3 rd_addr"}, 32'(rd_addr), 32'(rd));
        chk({tag, " R3 rd_data"}, rd_data, link);
        chk({tag, " R2 pc_next"}, pc_next, tgt);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset busy", 32'(busy), 0);
        chk("R8 reset done", 32'(done), 0);
        chk("R8 reset writes", 32'({rd_we, pc_we, msr_we, resv_clr, exc_raise, pfx_clr}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [4:0]  rd;
            logic [31:0] link;
            rd   = 5'(i + 1);
            link = 32'h0000_2000 + 32'(i * 4);
            instr = mk(rd, VT[i].imm);
            pc = link; pfx_valid = VT[i].pv; pfx_hi = VT[i].ph; msr_in = VT[i].msr;
            cfg_mmu_en = VT[i].mmu; cfg_dbg_en = VT[i].dbg; cfg_base_vec = VT[i].base;
            issue = 1'b1;
            @(negedge clk);
            issue = 1'b0;
            chk("R8 busy c1", 32'(busy), 1);
            chk("R8 no early done", 32'(done | rd_we | exc_raise), 0);
            @(negedge clk);
            chk("R8 busy c2", 32'(busy), 1);
            @(negedge clk);
            chk("R8 done c3", 32'(done), 1);
            chk("R8 busy low at done", 32'(busy), 0);
            chk("R9 pfx_clr", 32'(pfx_clr), 1);
            if (VT[i].exc) begin
                chk("R4 exc_raise", 32'(exc_raise), 1);
                chk("R4 exc_code", 32'(exc_code), 32'h7);
                chk("R5 no writes", 32'({rd_we, pc_we, msr_we, resv_clr}), 0);
            end else begin
                chk("R3/R10 exc_raise low", 32'(exc_raise), 0);
                chk("R3 rd_we", 32'(rd_we), 1);
                chk("R3 rd_addr", 32'(rd_addr), 32'(rd));
                chk("R3 rd_data", rd_data, link);
                chk("R3 pc_we", 32'(pc_we), 1);
                chk("R3 msr_we", 32'(msr_we), 1);
                chk("R3 resv_clr", 32'(resv_clr), 1);
                chk("R2/R7 pc_next", pc_next, VT[i].epc);
                chk("R3/R6/R10/R11 msr_out", msr_out, VT[i].emsr);
            end
            @(negedge clk);
            chk("R8 idle after done", 32'({busy, done}), 0);
        end
        pfx_valid = 1'b0; msr_in = '0; cfg_mmu_en = 1'b0; cfg_dbg_en = 1'b0; cfg_base_vec = '0;

        // R1: wrong opcode and wrong register-A field are not accepted
        instr = {6'b101111, 5'd3, 5'b01100, 16'h0040}; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        chk("R1 bad opcode busy", 32'(busy), 0);
        instr = {6'b101110, 5'd3, 5'b01101, 16'h0040}; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        chk("R1 bad ra busy", 32'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R1 no done", 32'({done, rd_we, pc_we}), 0);

        // R12: issue while busy is ignored
        instr = mk(5'd7, 16'h0300); pc = 32'h0000_4000; issue = 1'b1;
        @(negedge clk);
        instr = mk(5'd9, 16'h0500); pc = 32'h0000_5000;
        @(negedge clk);
        issue = 1'b0;
        @(negedge clk);
        chk_commit("R12 busy-ignore", 5'd7, 32'h0000_4000, 32'h0000_0300);
        @(negedge clk);
        chk("R12 no second done", 32'({busy, done}), 0);

        // R12: back-to-back, next issue lands on the done cycle
        instr = mk(5'd4, 16'h0600); pc = 32'h0000_6000; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        repeat (2) @(negedge clk);
        instr = mk(5'd5, 16'hFFF0); pc = 32'h0000_7000; issue = 1'b1;
        chk_commit("R12 first of pair", 5'd4, 32'h0000_6000, 32'h0000_0600);
        @(negedge clk);
        issue = 1'b0;
        chk("R12 second accepted", 32'(busy), 1);
        repeat (2) @(negedge clk);
        chk_commit("R12 second of pair", 5'd5, 32'h0000_7000, 32'hFFFF_FFF0);

        // R8: reset in flight cancels the instruction
        @(negedge clk);
        instr = mk(5'd6, 16'h0700); issue = 1'b1;
        @(negedge clk);
        issue = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 reset cancels", 32'({busy, done}), 0);
        repeat (3) @(negedge clk);
        chk("R8 no commit after reset", 32'({done, rd_we, pc_we, exc_raise}), 0);

        finish_sim();
    end
endmodule